// File: doc/BRIEF.md
# Memory Range Zero-Fill Engine

This block clears a contiguous range of physical memory when software asks for it. Software programs the first and the last byte address of the range, both inclusive, through a 64-bit register port. It then writes an operation code to the command register. When the code is the zero-fill code, the engine walks the range from the first address upward. It issues one write request per chunk, and each request carries an address, a byte count and all-zero data.

No chunk is larger than a parameterised maximum, 4096 bytes by default, and the last chunk holds whatever length is left. A request stays on the master port until the memory side accepts it with `mem_ready`. A busy flag covers the whole operation, and a one-cycle done pulse marks its end. Any other code is rejected and sets a sticky error bit. A range whose last address is below its first is also rejected, and it also sets the error bit. Neither case causes any memory traffic.

Top module: `zfill_engine`

## Requirements
- R1: The first-address register (offset 0x3030), the last-address register (offset 0x3038) and the command register (offset 0x3800) each read back the last 64-bit value written to them.
- R2: The status register at offset 0x3808 reads busy in bit 0 and the sticky error flag in bit 1. A write to it with bit 1 set clears the error flag.
- R3: Writing 0x11 to the command register zero-fills the inclusive range. The total of all accepted byte counts equals last minus first plus one, and `mem_data` is zero on every request.
- R4: The chunks cover the range in order, without gaps, starting at the first address. Each chunk's byte count is the smaller of 4096 and the remaining length. A pending request holds its address and byte count until `mem_ready` accepts it.
- R5: `busy` rises on the clock edge that takes the command write and falls on the edge that accepts the final chunk.
- R6: `done_irq` is high for exactly one cycle, in the cycle after the final chunk is accepted.
- R7: A command value other than 0x11 sets the error flag. It raises neither `mem_valid`, `busy` nor `done_irq`.
- R8: A 0x11 command whose last address is below its first sets the error flag and pulses `done_irq` in the next cycle. It produces no memory request.
- R9: A command write while busy is ignored. The command register keeps its value, the error flag does not change and the fill in progress is not disturbed.
- R10: After reset, `busy`, `mem_valid` and `done_irq` are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on reg_addr) |
| mem_valid | output | 1 | Write request pending |
| mem_addr | output | ADDR_W | Chunk start byte address |
| mem_len | output | LEN_W | Chunk byte count |
| mem_data | output | 64 | Write data (always zero) |
| mem_ready | input | 1 | Memory accepts the pending request |
| busy | output | 1 | Fill in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The fill is swept over range lengths on both sides of each chunk boundary: one and two bytes, one byte short of a chunk, exactly one and two chunks, one byte past, and a length spanning four chunks. These separate an off-by-one in the inclusive length from a wrong truncation of the last chunk. Each length runs from two different first addresses and under three acceptance patterns: always ready, every other cycle and every third cycle. The stall patterns show whether a held request keeps its address and count and whether the address advances only on acceptance. Separate runs cover the reversed range, an unknown code and a second command issued mid-fill. Those runs tell the two error paths apart and confirm that the ignored command leaves the fill in progress undisturbed.

// File: rtl/zfill_engine.sv
module zfill_engine #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 4096,
  parameter int LEN_W       = $clog2(CHUNK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [15:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic [63:0]       mem_data,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done_irq
);
  localparam logic [15:0] OFS_FIRST = 16'h3030;
  localparam logic [15:0] OFS_LAST  = 16'h3038;
  localparam logic [15:0] OFS_CMD   = 16'h3800;
  localparam logic [15:0] OFS_STAT  = 16'h3808;
  localparam logic [63:0] OP_ZERO   = 64'h11;
  localparam logic [ADDR_W:0] CHUNK = (ADDR_W+1)'(CHUNK_BYTES);

  logic [63:0]       first_q, last_q, cmd_q;
  logic              err_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W:0]   rem_q;

  wire cmd_wr  = reg_we && reg_addr == OFS_CMD && !busy;
  wire stat_wr = reg_we && reg_addr == OFS_STAT;
  wire reverse = last_q[ADDR_W-1:0] < first_q[ADDR_W-1:0];
  wire [ADDR_W:0] span = {1'b0, last_q[ADDR_W-1:0]} - {1'b0, first_q[ADDR_W-1:0]} + 1'b1;
  wire [ADDR_W:0] chunk = (rem_q > CHUNK) ? CHUNK : rem_q;
  wire accept = mem_valid && mem_ready;

  assign mem_valid = busy;
  assign mem_addr  = cur_q;
  assign mem_len   = chunk[LEN_W-1:0];
  assign mem_data  = '0;

  always_comb begin
    case (reg_addr)
      OFS_FIRST: reg_rdata = first_q;
      OFS_LAST:  reg_rdata = last_q;
      OFS_CMD:   reg_rdata = cmd_q;
      OFS_STAT:  reg_rdata = {62'd0, err_q, busy};
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      last_q   <= '0;
      cmd_q    <= '0;
      err_q    <= 1'b0;
      busy     <= 1'b0;
      done_irq <= 1'b0;
      cur_q    <= '0;
      rem_q    <= '0;
    end else begin
      done_irq <= 1'b0;
      if (reg_we && reg_addr == OFS_FIRST) first_q <= reg_wdata;
      if (reg_we && reg_addr == OFS_LAST)  last_q  <= reg_wdata;
      if (stat_wr && reg_wdata[1]) err_q <= 1'b0;
      if (cmd_wr) begin
        cmd_q <= reg_wdata;
        if (reg_wdata != OP_ZERO) begin
          err_q <= 1'b1;
        end else if (reverse) begin
          err_q    <= 1'b1;
          done_irq <= 1'b1;
        end else begin
          busy  <= 1'b1;
          cur_q <= first_q[ADDR_W-1:0];
          rem_q <= span;
        end
      end
      if (accept) begin
        cur_q <= cur_q + ADDR_W'(chunk);
        rem_q <= rem_q - chunk;
        if (rem_q == chunk) begin
          busy     <= 1'b0;
          done_irq <= 1'b1;
        end
      end
    end
  end
endmodule

module zfill_engine_chk #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 4096,
  parameter int LEN_W       = $clog2(CHUNK_BYTES) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LEN_W-1:0]  mem_len,
  input logic              mem_ready,
  input logic              busy,
  input logic              done_irq
);
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != 0 && int'(mem_len) <= CHUNK_BYTES)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len))); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && busy) |=> (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'($past(mem_len)))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq); // R5
endmodule

bind zfill_engine zfill_engine_chk #(.ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .mem_len(mem_len), .mem_ready(mem_ready), .busy(busy), .done_irq(done_irq));

// File: tb/test_zfill_engine.sv
module test_zfill_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic mem_valid, mem_ready = 1'b0, busy, done_irq;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_len;
  logic [63:0] mem_data;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zfill_engine i_zfill_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_data(mem_data),
    .mem_ready(mem_ready), .busy(busy), .done_irq(done_irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fill(input logic [31:0] first, input int len, input int mode);
    logic [31:0] exp_addr;
    int rem, nchunks, bad, k, want;
    logic [63:0] st;
    mem_ready = 1'b0;
    wr(16'h3030, 64'(first));
    wr(16'h3038, 64'(first + 32'(len) - 1));
    wr(16'h3800, 64'h11);
    chk(busy === 1'b1, "R5 busy after command", 64'(busy), 64'd1);
    exp_addr = first; rem = len; nchunks = 0; bad = 0; k = 0;
    while (rem > 0 && k < 100000) begin
      mem_ready = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(k % 2) : 1'(k % 3 == 2);
      #1;
      if (!mem_valid || !busy) begin
        bad++; rem = 0;
      end else if (mem_ready) begin
        want = (rem > 4096) ? 4096 : rem;
        if (mem_addr !== exp_addr || int'(mem_len) != want || mem_data !== 64'd0) begin
          bad++;
          $display("FAIL R4 chunk %0d: actual addr 0x%0h len %0d expected addr 0x%0h len %0d",
                   nchunks, mem_addr, mem_len, exp_addr, want);
        end
        exp_addr = exp_addr + 32'(want); rem -= want; nchunks++;
      end
      @(negedge clk); k++;
    end
    mem_ready = 1'b0;
    chk(bad == 0, "R3 R4 chunk sequence", 64'(bad), 64'd0);
    chk(nchunks == (len + 4095) / 4096, "R4 chunk count", 64'(nchunks), 64'((len + 4095) / 4096));
    chk(busy === 1'b0 && done_irq === 1'b1, "R5 R6 end of fill", {busy, done_irq}, 64'b01);
    @(negedge clk);
    chk(done_irq === 1'b0, "R6 done single cycle", 64'(done_irq), 64'd0);
    rd(16'h3808, st);
    chk(st == 64'd0, "R2 status idle no error", st, 64'd0);
  endtask

  initial begin : main
    logic [63:0] v;
    int lens[8] = '{1, 2, 4095, 4096, 4097, 8191, 8192, 12289};
    logic [31:0] bases[2] = '{32'h0000_1000, 32'h0012_3457};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && mem_valid === 1'b0 && done_irq === 1'b0, "R10 reset outputs",
        {busy, mem_valid, done_irq}, 64'd0);
    rd(16'h3030, v); chk(v == 0, "R10 first reg reset", v, 0);
    rd(16'h3800, v); chk(v == 0, "R10 cmd reg reset", v, 0);

    wr(16'h3030, 64'hDEAD_BEEF_0000_1234);
    wr(16'h3038, 64'h0123_4567_89AB_CDEF);
    rd(16'h3030, v); chk(v == 64'hDEAD_BEEF_0000_1234, "R1 first readback", v, 64'hDEAD_BEEF_0000_1234);
    rd(16'h3038, v); chk(v == 64'h0123_4567_89AB_CDEF, "R1 last readback", v, 64'h0123_4567_89AB_CDEF);

    for (int b = 0; b < 2; b++)
      for (int l = 0; l < 8; l++)
        for (int m = 0; m < 3; m++)
          fill(bases[b], lens[l], m);
    rd(16'h3800, v); chk(v == 64'h11, "R1 cmd readback", v, 64'h11);

    // R7 unknown code
    wr(16'h3030, 64'h100); wr(16'h3038, 64'h1ff);
    wr(16'h3800, 64'h22);
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        #1 if (mem_valid || busy || done_irq) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R7 unknown code quiet", 64'(seen), 0);
    end
    rd(16'h3808, v); chk(v == 64'h2, "R7 unknown code error", v, 64'h2);
    rd(16'h3800, v); chk(v == 64'h22, "R1 cmd readback unknown", v, 64'h22);
    wr(16'h3808, 64'h2);
    rd(16'h3808, v); chk(v == 64'h0, "R2 error clear", v, 0);
    wr(16'h3808, 64'h1);
    wr(16'h3800, 64'h33);
    wr(16'h3808, 64'h1);
    rd(16'h3808, v); chk(v == 64'h2, "R2 write without bit1 keeps error", v, 64'h2);
    wr(16'h3808, 64'h2);

    // R8 reversed range
    wr(16'h3030, 64'h2000); wr(16'h3038, 64'h1fff);
    wr(16'h3800, 64'h11);
    chk(done_irq === 1'b1 && mem_valid === 1'b0 && busy === 1'b0, "R8 reversed done",
        {done_irq, mem_valid, busy}, 64'b100);
    @(negedge clk);
    chk(done_irq === 1'b0 && mem_valid === 1'b0, "R8 reversed no request", {done_irq, mem_valid}, 0);
    rd(16'h3808, v); chk(v == 64'h2, "R8 reversed error", v, 64'h2);
    wr(16'h3808, 64'h2);

    // R9 command while busy
    wr(16'h3030, 64'h4000); wr(16'h3038, 64'h4fff);
    wr(16'h3800, 64'h11);
    wr(16'h3800, 64'h44);
    rd(16'h3800, v); chk(v == 64'h11, "R9 cmd unchanged while busy", v, 64'h11);
    rd(16'h3808, v); chk(v == 64'h1, "R9 busy no error", v, 64'h1);
    #1 chk(mem_addr == 32'h4000 && mem_len == 13'd4096, "R9 fill undisturbed",
           {mem_addr, 19'd0, mem_len}, {32'h4000, 19'd0, 13'd4096});
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(busy === 1'b0 && done_irq === 1'b1, "R9 R6 fill completes", {busy, done_irq}, 64'b01);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule